// File: doc/BRIEF.md
# ADC Pair Trigger Selector

This block decides when one analog input pair is converted. A 5-bit source code picks one trigger from a set of hardware events: a global software strobe, four PWM primary, four PWM secondary and four PWM current-limit triggers, one PWM special event and two timer period matches. The code can also pick a per-pair software start bit, or pick nothing. When the chosen trigger fires, the block raises a pending flag. It then asks a shared converter for service and keeps the flag up until that converter reports the work done. It can also raise an interrupt pulse at completion.

Software sets the source code, the software start bit and the interrupt enable through a single write-enable port that writes all three at once. The current values of these fields come back on the readback outputs. The conversion request toward the converter is a valid/ready pair. `conv_req` is the valid signal, and once it is high it stays high until `conv_gnt` (ready) is seen in the same cycle. The converter may hold `conv_gnt` low for any number of cycles, and the request simply waits. After a grant, the converter reports the end of the work with a single-cycle `conv_done`.

Top module: `adc_pair_trigger`

## Requirements
- R1: A synchronous active-high reset clears the source code, software start bit, interrupt enable and pending flag, and `conv_req` is low.
- R2: Source codes map as follows. 2 selects the global software strobe and 3 the PWM special event. 4..7 select PWM generators 1..4 primary, 14..17 select generators 1..4 secondary, and 23..26 select generators 1..4 current-limit. 12 selects timer 1 match and 31 selects timer 2 match. A rising edge on the selected input, seen at a clock edge, makes `pending` read 1 after that edge.
- R3: Code 0 and the reserved codes 8..11, 13, 18..22 and 27..30 never set `pending`, whatever the trigger inputs do.
- R4: Inputs that are not selected have no effect. A trigger held high starts only one conversion, on its rising edge.
- R5: The software start bit (`sw_go_q`) starts a conversion only while the source code is 1. Under any other code it stays set and starts nothing.
- R6: The hardware clears `sw_go_q` at the same clock edge where it sets `pending` from it.
- R7: `conv_req` is high while `pending` is 1 and no grant has been taken. It stays high with back-pressure until a cycle with `conv_gnt` high, and it drops after that grant.
- R8: `pending` clears at the edge of a `conv_done` that follows a grant. A `conv_done` with no granted request leaves `pending` unchanged.
- R9: `irq` is a one-cycle pulse in the `conv_done` cycle that completes the pair, and only when the interrupt enable reads 1.
- R10: A trigger edge that arrives while `pending` is 1 is dropped, so one pending request leads to exactly one conversion.
- R11: A write that sets the software start bit with code 1, made in the same cycle as the completing `conv_done`, produces a new request on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the three config fields |
| cfg_src_sel | input | 5 | Source code to write |
| cfg_sw_go | input | 1 | Software start bit to write |
| cfg_irq_en | input | 1 | Interrupt enable to write |
| glb_sw_trig | input | 1 | Global software trigger |
| pwm_pri_trig | input | 4 | PWM generator 1..4 primary triggers (bit 0 = generator 1) |
| pwm_sec_trig | input | 4 | PWM generator 1..4 secondary triggers |
| pwm_ilim_trig | input | 4 | PWM generator 1..4 current-limit triggers |
| pwm_special_trig | input | 1 | PWM special event trigger |
| tmr1_match | input | 1 | Timer 1 period match |
| tmr2_match | input | 1 | Timer 2 period match |
| conv_req | output | 1 | Conversion request (valid) |
| conv_gnt | input | 1 | Converter accepts request (ready) |
| conv_done | input | 1 | Single-cycle end of granted conversion |
| src_sel_q | output | 5 | Current source code |
| sw_go_q | output | 1 | Current software start bit |
| irq_en_q | output | 1 | Current interrupt enable |
| pending | output | 1 | Conversion pending flag |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The properties assume the following about the converter. It pulses `conv_done` for exactly one cycle and only for a request it has granted. It raises `conv_gnt` only while that request waits. It never reports completion for a pair it is not serving. The hardware-clear check on the software start bit also assumes no write lands on the edge where the request is taken. The stimulus respects all of this. Grants are issued only while `conv_req` reads 1. Every completion is a one-cycle pulse after its grant. The single stray `conv_done`, which exercises R8, is sent while no grant is outstanding. Writes are placed so that no write falls on an edge where a pending flag is raised from the software bit.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

  localparam int SEL_W   = 5;
  localparam int NUM_GEN = 4;

  // source codes; the generator groups are ranges starting at a base code
  typedef enum logic [SEL_W-1:0] {
    SRC_NONE        = 5'd0,
    SRC_SW_PAIR     = 5'd1,
    SRC_SW_GLOBAL   = 5'd2,
    SRC_PWM_SPECIAL = 5'd3,
    SRC_TMR1        = 5'd12,
    SRC_TMR2        = 5'd31
  } src_code_e;

  localparam int PRI_CODE_BASE  = 4;
  localparam int SEC_CODE_BASE  = 14;
  localparam int ILIM_CODE_BASE = 23;

  // bit positions in the internal hardware trigger vector
  localparam int HW_GLOBAL    = 0;
  localparam int HW_SPECIAL   = 1;
  localparam int HW_TMR1      = 2;
  localparam int HW_TMR2      = 3;
  localparam int HW_PRI_BASE  = 4;
  localparam int HW_SEC_BASE  = HW_PRI_BASE + NUM_GEN;
  localparam int HW_ILIM_BASE = HW_SEC_BASE + NUM_GEN;
  localparam int HW_NUM       = HW_ILIM_BASE + NUM_GEN;

  function automatic logic src_is_active(input logic [SEL_W-1:0] code);
    return code inside {[5'd1:5'd7], 5'd12, [5'd14:5'd17], [5'd23:5'd26], 5'd31};
  endfunction

endpackage

// File: rtl/trig_edge_detect.sv
module trig_edge_detect #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] level_in,
  output logic [WIDTH-1:0] rise_out
);

  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= level_in;
  end

  assign rise_out = level_in & ~prev_q;

endmodule

// File: rtl/trig_source_mux.sv
module trig_source_mux
  import adc_trig_pkg::*;
(
  input  logic [SEL_W-1:0]  sel,
  input  logic [HW_NUM-1:0] hw_rise,
  input  logic              sw_go,
  output logic              hw_hit,
  output logic              sw_hit
);

  always_comb begin
    hw_hit = 1'b0;
    if (sel == SRC_SW_GLOBAL)   hw_hit = hw_rise[HW_GLOBAL];
    if (sel == SRC_PWM_SPECIAL) hw_hit = hw_rise[HW_SPECIAL];
    if (sel == SRC_TMR1)        hw_hit = hw_rise[HW_TMR1];
    if (sel == SRC_TMR2)        hw_hit = hw_rise[HW_TMR2];
    for (int g = 0; g < NUM_GEN; g++) begin
      if (sel == SEL_W'(PRI_CODE_BASE + g))  hw_hit = hw_rise[HW_PRI_BASE + g];
      if (sel == SEL_W'(SEC_CODE_BASE + g))  hw_hit = hw_rise[HW_SEC_BASE + g];
      if (sel == SEL_W'(ILIM_CODE_BASE + g)) hw_hit = hw_rise[HW_ILIM_BASE + g];
    end
  end

  assign sw_hit = (sel == SRC_SW_PAIR) && sw_go;

endmodule

// File: rtl/pair_req_tracker.sv
module pair_req_tracker (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic irq_en,
  input  logic conv_gnt,
  input  logic conv_done,
  output logic taken,
  output logic pending,
  output logic conv_req,
  output logic irq
);

  logic in_flight_q;
  logic finish;

  assign finish   = in_flight_q && conv_done;
  assign taken    = !pending && start;
  assign conv_req = pending && !in_flight_q;
  assign irq      = finish && irq_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending     <= 1'b0;
      in_flight_q <= 1'b0;
    end else if (finish) begin
      pending     <= 1'b0;
      in_flight_q <= 1'b0;
    end else begin
      if (taken)               pending     <= 1'b1;
      if (conv_req && conv_gnt) in_flight_q <= 1'b1;
    end
  end

endmodule

// File: rtl/adc_pair_trigger.sv
module adc_pair_trigger
  import adc_trig_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [SEL_W-1:0]   cfg_src_sel,
  input  logic               cfg_sw_go,
  input  logic               cfg_irq_en,
  input  logic               glb_sw_trig,
  input  logic [NUM_GEN-1:0] pwm_pri_trig,
  input  logic [NUM_GEN-1:0] pwm_sec_trig,
  input  logic [NUM_GEN-1:0] pwm_ilim_trig,
  input  logic               pwm_special_trig,
  input  logic               tmr1_match,
  input  logic               tmr2_match,
  output logic               conv_req,
  input  logic               conv_gnt,
  input  logic               conv_done,
  output logic [SEL_W-1:0]   src_sel_q,
  output logic               sw_go_q,
  output logic               irq_en_q,
  output logic               pending,
  output logic               irq
);

  logic [HW_NUM-1:0] hw_level;
  logic [HW_NUM-1:0] hw_rise;
  logic              hw_hit;
  logic              sw_hit;
  logic              taken;

  always_comb begin
    hw_level                             = '0;
    hw_level[HW_GLOBAL]                  = glb_sw_trig;
    hw_level[HW_SPECIAL]                 = pwm_special_trig;
    hw_level[HW_TMR1]                    = tmr1_match;
    hw_level[HW_TMR2]                    = tmr2_match;
    hw_level[HW_PRI_BASE  +: NUM_GEN]    = pwm_pri_trig;
    hw_level[HW_SEC_BASE  +: NUM_GEN]    = pwm_sec_trig;
    hw_level[HW_ILIM_BASE +: NUM_GEN]    = pwm_ilim_trig;
  end

  trig_edge_detect #(.WIDTH(HW_NUM)) i_edge (
    .clk      (clk),
    .rst      (rst),
    .level_in (hw_level),
    .rise_out (hw_rise)
  );

  trig_source_mux i_mux (
    .sel     (src_sel_q),
    .hw_rise (hw_rise),
    .sw_go   (sw_go_q),
    .hw_hit  (hw_hit),
    .sw_hit  (sw_hit)
  );

  pair_req_tracker i_track (
    .clk       (clk),
    .rst       (rst),
    .start     (hw_hit || sw_hit),
    .irq_en    (irq_en_q),
    .conv_gnt  (conv_gnt),
    .conv_done (conv_done),
    .taken     (taken),
    .pending   (pending),
    .conv_req  (conv_req),
    .irq       (irq)
  );

  // config fields; a software write wins over the hardware clear
  always_ff @(posedge clk) begin
    if (rst) begin
      src_sel_q <= SRC_NONE;
      sw_go_q   <= 1'b0;
      irq_en_q  <= 1'b0;
    end else if (cfg_we) begin
      src_sel_q <= cfg_src_sel;
      sw_go_q   <= cfg_sw_go;
      irq_en_q  <= cfg_irq_en;
    end else if (taken && sw_hit) begin
      sw_go_q   <= 1'b0;
    end
  end

endmodule

// File: rtl/adc_pair_trigger_chk.sv
module adc_pair_trigger_chk
  import adc_trig_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic             conv_req,
  input logic             conv_gnt,
  input logic             conv_done,
  input logic [SEL_W-1:0] src_sel_q,
  input logic             sw_go_q,
  input logic             irq_en_q,
  input logic             pending,
  input logic             irq
);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!pending && !sw_go_q && !irq_en_q && src_sel_q == '0 && !conv_req));

  assert_no_reserved_start_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(pending) |-> src_is_active($past(src_sel_q)));

  assert_sw_cleared_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(pending) && $past(src_sel_q) == SRC_SW_PAIR && !$past(cfg_we)) |-> !sw_go_q);

  assert_req_held_R7: assert property (@(posedge clk) disable iff (rst)
    (conv_req && !conv_gnt) |=> conv_req);

  assert_req_has_pending_R7: assert property (@(posedge clk) disable iff (rst)
    conv_req |-> pending);

  assert_clear_on_done_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(pending) |-> $past(conv_done));

  assert_pending_holds_R10: assert property (@(posedge clk) disable iff (rst)
    (pending && !conv_done) |=> pending);

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> (irq_en_q && conv_done && pending));

  assert_irq_single_R9: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

endmodule

bind adc_pair_trigger adc_pair_trigger_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_we    (cfg_we),
  .conv_req  (conv_req),
  .conv_gnt  (conv_gnt),
  .conv_done (conv_done),
  .src_sel_q (src_sel_q),
  .sw_go_q   (sw_go_q),
  .irq_en_q  (irq_en_q),
  .pending   (pending),
  .irq       (irq)
);

// File: tb/test_adc_pair_trigger.sv
module test_adc_pair_trigger;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [4:0] cfg_src_sel = '0;
  logic cfg_sw_go = 1'b0;
  logic cfg_irq_en = 1'b0;
  logic [15:0] trg = '0; // 0 glb, 1-4 pri, 5-8 sec, 9-12 ilim, 13 special, 14 t1, 15 t2
  logic conv_gnt = 1'b0;
  logic conv_done = 1'b0;
  logic conv_req, sw_go_q, irq_en_q, pending, irq;
  logic [4:0] src_sel_q;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  adc_pair_trigger i_adc_pair_trigger (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_src_sel(cfg_src_sel),
    .cfg_sw_go(cfg_sw_go), .cfg_irq_en(cfg_irq_en),
    .glb_sw_trig(trg[0]), .pwm_pri_trig(trg[4:1]), .pwm_sec_trig(trg[8:5]),
    .pwm_ilim_trig(trg[12:9]), .pwm_special_trig(trg[13]),
    .tmr1_match(trg[14]), .tmr2_match(trg[15]),
    .conv_req(conv_req), .conv_gnt(conv_gnt), .conv_done(conv_done),
    .src_sel_q(src_sel_q), .sw_go_q(sw_go_q), .irq_en_q(irq_en_q),
    .pending(pending), .irq(irq)
  );

  typedef struct packed {
    logic [4:0] sel;
    logic [3:0] idx;
    logic       hit;
    logic [1:0] tag; // 0: R2, 1: R3, 2: R4
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{5'd2,  4'd0,  1'b1, 2'd0}, '{5'd3,  4'd13, 1'b1, 2'd0},
    '{5'd4,  4'd1,  1'b1, 2'd0}, '{5'd7,  4'd4,  1'b1, 2'd0},
    '{5'd5,  4'd2,  1'b1, 2'd0}, '{5'd12, 4'd14, 1'b1, 2'd0},
    '{5'd14, 4'd5,  1'b1, 2'd0}, '{5'd17, 4'd8,  1'b1, 2'd0},
    '{5'd23, 4'd9,  1'b1, 2'd0}, '{5'd26, 4'd12, 1'b1, 2'd0},
    '{5'd31, 4'd15, 1'b1, 2'd0}, '{5'd4,  4'd2,  1'b0, 2'd2},
    '{5'd14, 4'd1,  1'b0, 2'd2}, '{5'd1,  4'd0,  1'b0, 2'd2},
    '{5'd0,  4'd0,  1'b0, 2'd1}, '{5'd8,  4'd1,  1'b0, 2'd1},
    '{5'd13, 4'd14, 1'b0, 2'd1}, '{5'd18, 4'd5,  1'b0, 2'd1},
    '{5'd22, 4'd9,  1'b0, 2'd1}, '{5'd27, 4'd12, 1'b0, 2'd1},
    '{5'd30, 4'd15, 1'b0, 2'd1}, '{5'd11, 4'd13, 1'b0, 2'd1}
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [4:0] sel, input logic sw, input logic ien);
    cfg_we = 1'b1; cfg_src_sel = sel; cfg_sw_go = sw; cfg_irq_en = ien;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input int i);
    trg[i] = 1'b1; tick(); trg[i] = 1'b0; tick();
  endtask

  task automatic finish_conv(input logic exp_irq);
    check("R7 req before grant", conv_req, 1);
    conv_gnt = 1'b1; tick(); conv_gnt = 1'b0;
    check("R7 req drops after grant", conv_req, 0);
    conv_done = 1'b1; #1;
    check("R9 irq in done cycle", irq, exp_irq);
    tick(); conv_done = 1'b0; #1;
    check("R9 irq one cycle", irq, 0);
    check("R8 pending cleared", pending, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    check("R1 pending", pending, 0);
    check("R1 sel", src_sel_q, 0);
    check("R1 sw", sw_go_q, 0);
    check("R1 ien", irq_en_q, 0);
    check("R1 req", conv_req, 0);

    foreach (VECS[k]) begin
      write_cfg(VECS[k].sel, 1'b0, 1'b1);
      pulse(int'(VECS[k].idx));
      case (VECS[k].tag)
        2'd0:    check("R2 selected edge", pending, VECS[k].hit);
        2'd1:    check("R3 reserved code", pending, VECS[k].hit);
        default: check("R4 unselected input", pending, VECS[k].hit);
      endcase
      if (VECS[k].hit) finish_conv(1'b1);
    end

    // R5: software bit under a non-software code
    write_cfg(5'd4, 1'b1, 1'b1);
    tick(); tick();
    check("R5 no start", pending, 0);
    check("R5 bit kept", sw_go_q, 1);
    write_cfg(5'd1, 1'b1, 1'b1);
    check("R5 not yet", pending, 0);
    tick();
    check("R5 start", pending, 1);
    check("R6 hw clear", sw_go_q, 0);
    // R7 back-pressure
    for (int c = 0; c < 5; c++) begin
      tick();
      check("R7 held", conv_req, 1);
    end
    // R8 stray done with no grant
    conv_done = 1'b1; #1;
    check("R9 no irq stray", irq, 0);
    tick(); conv_done = 1'b0;
    check("R8 stray done ignored", pending, 1);
    finish_conv(1'b1);

    // R9 disabled interrupt
    write_cfg(5'd4, 1'b0, 1'b0);
    pulse(1);
    check("R2 pri1", pending, 1);
    finish_conv(1'b0);

    // R10 second edge while pending
    write_cfg(5'd4, 1'b0, 1'b1);
    pulse(1);
    pulse(1);
    finish_conv(1'b1);
    tick(); tick();
    check("R10 no second request", pending, 0);
    check("R10 no second req", conv_req, 0);

    // R4 level held high
    write_cfg(5'd5, 1'b0, 1'b1);
    trg[2] = 1'b1; tick(); tick();
    check("R4 first edge", pending, 1);
    finish_conv(1'b1);
    tick(); tick();
    check("R4 level no retrigger", pending, 0);
    trg[2] = 1'b0; tick();

    // R11 software write during done
    write_cfg(5'd1, 1'b1, 1'b1);
    tick();
    check("R11 first pending", pending, 1);
    conv_gnt = 1'b1; tick(); conv_gnt = 1'b0;
    conv_done = 1'b1; cfg_we = 1'b1; cfg_src_sel = 5'd1; cfg_sw_go = 1'b1; cfg_irq_en = 1'b1;
    tick();
    conv_done = 1'b0; cfg_we = 1'b0;
    check("R11 cleared", pending, 0);
    check("R11 bit set", sw_go_q, 1);
    tick();
    check("R11 new request", pending, 1);
    finish_conv(1'b1);

    // R1 reset mid-request
    write_cfg(5'd2, 1'b0, 1'b1);
    pulse(0);
    rst = 1'b1; tick(); rst = 1'b0;
    check("R1 reset clears pending", pending, 0);
    check("R1 reset clears sel", src_sel_q, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule